// File: doc/BRIEF.md
# Six-Source Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It takes six request sources: two active-low external pins, the overflow flags of three timers and the serial port flag. It holds one pending vector for the CPU at a time. Each machine cycle lasts a fixed number of clocks. The block polls its sources once per machine cycle, at a fixed phase, and announces that phase on `poll_strobe`. A flag raised after that phase waits for the next poll. A timer that sets its flag late in the cycle is therefore serviced one machine cycle later than a timer that sets its flag early.

When the poll finds an enabled request, the block raises `irq_valid` with the vector address and a one-hot source code. It holds that offer until `cpu_ack`. From the acknowledge until `cpu_reti`, a service routine is running and no new offer is made. On the acknowledge, the block clears the flags that hardware owns: it pulses a clear line back to timer 0 or timer 1, or it clears its own internal edge flag for an external pin. The serial flag and the two flags of the third timer stay set until software clears them.

The enable input packs one bit per source, a master bit and one reserved bit. Each external pin works in level mode or in falling-edge mode, chosen by one input bit per pin.

Top module: `icu_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `irq_valid`, `clr_tmr0` and `clr_tmr1` are 0.
- R2: A source whose enable bit is 0 is never offered. The source order and index are ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4, tmr2=5, and enable bit i belongs to source index i.
- R3: When the master bit `en_reg[7]` is 0, no source is offered, whatever the per-source bits hold.
- R4: Bit `en_reg[6]` is reserved and has no effect on any output.
- R5: When several enabled requests are pending at a poll, the source with the lowest index wins, and `irq_src` is one-hot with bit i set for source index i.
- R6: `irq_vector` equals 0x0003 + 8 × (source index), so it ranges from 0x0003 to 0x002B.
- R7: The third timer requests while `tmr2_ovf` or `tmr2_ext` is high. Acknowledging it, or the serial source, pulses no clear line, so a flag still held is offered again after `cpu_reti`.
- R8: Requests are sampled only at the clock edge where `poll_strobe` is 1, and an offer appears at that edge. A flag raised just after a poll is not offered before the next poll.
- R9: Acknowledging timer 0 or timer 1 raises `clr_tmr0` or `clr_tmr1`, respectively, for exactly one clock in the cycle after the acknowledge edge. No other source raises them.
- R10: After `cpu_ack`, no offer is made until `cpu_reti` arrives, even if enabled requests are pending.
- R11: In level mode (`ext_edge[i]`=0), an external pin requests only if it is low at the poll, and a low pulse that ends before the poll is lost.
- R12: In edge mode (`ext_edge[i]`=1), a high-to-low change between two consecutive poll samples sets an internal flag. The flag stays set while the source is disabled or the pin has returned high. Acknowledging that source clears it.
- R13: An offer keeps its vector and source stable until it is acknowledged, even if a higher-priority request arrives in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_reg | input | 8 | Bits 0-5: per-source enables; bit 6: reserved; bit 7: master enable |
| ext_edge | input | 2 | Per external pin: 1 = falling-edge mode, 0 = level mode |
| ext_pin_n | input | 2 | External request pins, active low |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external event flag |
| ser_flag | input | 1 | Serial port flag (receive or transmit) |
| cpu_ack | input | 1 | CPU accepts the current offer |
| cpu_reti | input | 1 | CPU has returned from the service routine |
| poll_strobe | output | 1 | High in the clock whose closing edge is the poll point |
| irq_valid | output | 1 | An offer is pending |
| irq_vector | output | 16 | Vector address of the offered source |
| irq_src | output | 6 | One-hot code of the offered source |
| clr_tmr0 | output | 1 | One-clock clear pulse for the timer 0 flag |
| clr_tmr1 | output | 1 | One-clock clear pulse for the timer 1 flag |

## Verification
The embedded properties check, on every cycle, the properties that hold at each cycle: an offer starts only at a poll edge with the master bit set, an offer is one-hot and stays stable until acknowledged, no offer coexists with a running service routine, and clear pulses only follow an acknowledge. Priority order, vector values, the effect of each enable bit and the reserved bit, the one-cycle delay of late flags, the survival of an edge flag across polls and the re-offer of flags that software owns can only be shown by the bench. Its scenarios sweep every request pattern and every enable pattern and compare against an arithmetic model.

// File: rtl/icu_pkg.sv
// Shared constants for the interrupt controller.
// Assumes a fixed source order that is also the priority order.
package icu_pkg;
    localparam int NUM_SRC   = 6;
    localparam int NUM_EXT   = 2;
    localparam int EN_W      = 8;
    localparam int EN_RSVD   = 6;
    localparam int EN_MASTER = 7;

    // Source index, lowest value = highest priority.
    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;
endpackage

// File: rtl/icu_cycle_timer.sv
// Machine-cycle phase counter. It flags the one clock per machine
// cycle whose closing edge is the poll point.
// Assumes POLL_PHASE < CLKS_PER_CYCLE.
module icu_cycle_timer #(
    parameter int CLKS_PER_CYCLE = 12,
    parameter int POLL_PHASE     = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic poll
);
    localparam int PH_W = $clog2(CLKS_PER_CYCLE);

    logic [PH_W-1:0] phase;

    // Advance the phase and wrap at the end of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == PH_W'(CLKS_PER_CYCLE - 1))
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign poll = (phase == PH_W'(POLL_PHASE));

    assert_phase_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < CLKS_PER_CYCLE);
endmodule

// File: rtl/icu_ext_line.sv
// Handles one external request pin (active low). The pin is sampled once per
// machine cycle at the poll. In edge mode, a high-to-low change between
// two samples sets a flag that lasts until the source is acknowledged.
// In level mode, the request follows the pin.
module icu_ext_line (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic edge_mode,
    input  logic pin_n,
    input  logic clr,
    output logic req
);
    logic pin_q;
    logic flag;
    logic fall;

    assign fall = sample & pin_q & ~pin_n;

    // Keep the previous sample of the pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b1;
        else if (sample)
            pin_q <= pin_n;
    end

    // Set the edge flag on a detected fall and clear it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= edge_mode & (fall | (flag & ~clr));
    end

    assign req = edge_mode ? (flag | fall) : ~pin_n;

    assert_flag_only_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(edge_mode) && $past(sample));
endmodule

// File: rtl/icu_prio_arb.sv
// Fixed-priority selector. Request 0 wins, and the grant is one-hot or zero.
// Assumes N >= 2.
module icu_prio_arb #(
    parameter int N = 6,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign blocked[i+1] = blocked[i] | req[i];
        assign grant[i]     = req[i] & ~blocked[i];
    end

    assign any = blocked[N];

    // Encode the winning position as an index.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (grant[i]) idx = IDX_W'(i);
    end

    always_comb begin
        assert_grant_onehot_R5: assert ($onehot0(grant));
    end
endmodule

// File: rtl/icu_top.sv
// Six-source interrupt controller. It polls the gated requests at one fixed
// phase of every machine cycle and offers the winner to the CPU. It then runs
// the acknowledge / return handshake and clears the flags that hardware owns.
// Assumes the timer and serial flags are held by their owners until cleared.
module icu_top
    import icu_pkg::*;
#(
    parameter int CLKS_PER_CYCLE = 12,
    parameter int POLL_PHASE     = 6,
    parameter int VEC_W          = 16,
    parameter int VEC_BASE       = 3,
    parameter int VEC_STRIDE     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EN_W-1:0]    en_reg,
    input  logic [NUM_EXT-1:0] ext_edge,
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic               tmr0_flag,
    input  logic               tmr1_flag,
    input  logic               tmr2_ovf,
    input  logic               tmr2_ext,
    input  logic               ser_flag,
    input  logic               cpu_ack,
    input  logic               cpu_reti,
    output logic               poll_strobe,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [NUM_SRC-1:0] irq_src,
    output logic               clr_tmr0,
    output logic               clr_tmr1
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] gated;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    logic               in_svc;
    logic               take;
    logic               fire;
    logic [VEC_W-1:0]   vec_next;

    icu_cycle_timer #(
        .CLKS_PER_CYCLE(CLKS_PER_CYCLE),
        .POLL_PHASE    (POLL_PHASE)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .poll (poll_strobe)
    );

    // One line unit per external pin; ext i maps to source index 2*i.
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        icu_ext_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample   (poll_strobe),
            .edge_mode(ext_edge[e]),
            .pin_n    (ext_pin_n[e]),
            .clr      (fire & irq_src[2*e]),
            .req      (ext_req[e])
        );
    end

    // Gather the raw requests in priority order and apply the enables.
    always_comb begin
        raw_req            = '0;
        raw_req[SRC_EXT0]  = ext_req[0];
        raw_req[SRC_TMR0]  = tmr0_flag;
        raw_req[SRC_EXT1]  = ext_req[1];
        raw_req[SRC_TMR1]  = tmr1_flag;
        raw_req[SRC_SER]   = ser_flag;
        raw_req[SRC_TMR2]  = tmr2_ovf | tmr2_ext;
        gated = raw_req & en_reg[NUM_SRC-1:0] & {NUM_SRC{en_reg[EN_MASTER]}};
    end

    icu_prio_arb #(.N(NUM_SRC)) u_arb (
        .req  (gated),
        .grant(grant),
        .idx  (win_idx),
        .any  (win_any)
    );

    assign vec_next = VEC_W'(VEC_BASE + VEC_STRIDE * int'(win_idx));
    assign take     = poll_strobe & win_any & ~irq_valid & ~in_svc;
    assign fire     = cpu_ack & irq_valid;

    // Hold the offer from poll until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
            irq_src    <= '0;
        end else begin
            if (fire)
                irq_valid <= 1'b0;
            else if (take)
                irq_valid <= 1'b1;
            if (take) begin
                irq_vector <= vec_next;
                irq_src    <= grant;
            end
        end
    end

    // Track the running service routine between acknowledge and return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_svc <= 1'b0;
        else if (fire)
            in_svc <= 1'b1;
        else if (cpu_reti)
            in_svc <= 1'b0;
    end

    // Pulse the hardware clears for the two flag-owning timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_tmr0 <= 1'b0;
            clr_tmr1 <= 1'b0;
        end else begin
            clr_tmr0 <= fire & irq_src[SRC_TMR0];
            clr_tmr1 <= fire & irq_src[SRC_TMR1];
        end
    end

    assert_offer_needs_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(en_reg[EN_MASTER]));

    assert_rsvd_no_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_reg[EN_RSVD] && !en_reg[EN_MASTER]) |=> !$rose(irq_valid));

    assert_offer_at_poll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(poll_strobe));

    assert_src_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $countones(irq_src) == 1);

    assert_no_offer_in_svc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc |-> !irq_valid);

    assert_offer_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !cpu_ack) |=> irq_valid && $stable(irq_vector) && $stable(irq_src));

    assert_clr_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tmr0 || clr_tmr1) |-> in_svc && !irq_valid && !(clr_tmr0 && clr_tmr1));
endmodule

// File: tb/icu_top_test.sv
module icu_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] en_reg = 8'h00;
    logic [1:0] ext_edge = 2'b00;
    logic [1:0] ext_pin_n = 2'b11;
    logic       tmr0_flag = 1'b0, tmr1_flag = 1'b0, tmr2_ovf = 1'b0, tmr2_ext = 1'b0;
    logic       ser_flag = 1'b0, cpu_ack = 1'b0, cpu_reti = 1'b0;
    logic       poll_strobe, irq_valid, clr_tmr0, clr_tmr1;
    logic [15:0] irq_vector;
    logic [5:0]  irq_src;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icu_top uut (
        .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .ext_edge(ext_edge),
        .ext_pin_n(ext_pin_n), .tmr0_flag(tmr0_flag), .tmr1_flag(tmr1_flag),
        .tmr2_ovf(tmr2_ovf), .tmr2_ext(tmr2_ext), .ser_flag(ser_flag),
        .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .poll_strobe(poll_strobe),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_src(irq_src),
        .clr_tmr0(clr_tmr0), .clr_tmr1(clr_tmr1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model_idx(input logic [5:0] req, input logic [7:0] en);
        if (!en[7]) return -1;
        for (int i = 0; i < 6; i++)
            if (req[i] && en[i]) return i;
        return -1;
    endfunction

    task automatic drive_req(input logic [5:0] r, input bit alt);
        ext_pin_n[0] = ~r[0];
        tmr0_flag    = r[1];
        ext_pin_n[1] = ~r[2];
        tmr1_flag    = r[3];
        ser_flag     = r[4];
        tmr2_ovf     = r[5] & ~alt;
        tmr2_ext     = r[5] & alt;
    endtask

    // Stop at the falling edge just before a poll edge.
    task automatic to_poll();
        @(negedge clk);
        while (!poll_strobe) @(negedge clk);
    endtask

    task automatic ack_and_return();
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        cpu_reti = 1'b1;
        @(negedge clk);
        cpu_reti = 1'b0;
    endtask

    task automatic run_trial(input logic [5:0] req, input logic [7:0] en,
                             input bit alt, input string tag);
        int e;
        to_poll();
        en_reg = en;
        drive_req(req, alt);
        @(negedge clk);
        e = model_idx(req, en);
        chk({tag, " valid"}, int'(irq_valid), int'(e >= 0));
        if (e >= 0) begin
            chk("R6 vector", int'(irq_vector), 3 + 8 * e);
            chk({tag, " src"}, int'(irq_src), 1 << e);
            cpu_ack = 1'b1;
            @(negedge clk);
            cpu_ack = 1'b0;
            chk("R9 clr_tmr0", int'(clr_tmr0), int'(e == 1));
            chk("R9 clr_tmr1", int'(clr_tmr1), int'(e == 3));
            drive_req(6'd0, 1'b0);
            cpu_reti = 1'b1;
            @(negedge clk);
            cpu_reti = 1'b0;
            chk("R9 single pulse", int'(clr_tmr0 | clr_tmr1), 0);
        end else begin
            drive_req(6'd0, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(irq_valid), 0);
        chk("R1 clr in reset", int'(clr_tmr0 | clr_tmr1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(irq_valid), 0);
        chk("R1 clr after reset", int'(clr_tmr0 | clr_tmr1), 0);

        // R5 / R6: every request pattern, all enabled
        for (int r = 0; r < 64; r++)
            run_trial(6'(r), 8'hBF, bit'(r[0]), "R5");
        // R2: every per-source enable pattern, all requests
        for (int en = 0; en < 64; en++)
            run_trial(6'h3F, 8'h80 | 8'(en), 1'b0, "R2");
        // R3: master off
        run_trial(6'h3F, 8'h3F, 1'b0, "R3");
        run_trial(6'h3F, 8'h7F, 1'b1, "R3");
        // R4: reserved bit alone, with master, and over each single request
        run_trial(6'h3F, 8'h40, 1'b0, "R4");
        run_trial(6'h3F, 8'hC0, 1'b0, "R4");
        for (int r = 0; r < 6; r++)
            run_trial(6'(1 << r), 8'hFF, 1'b0, "R4");

        // R8: late flag waits for next poll; early flag taken at this poll
        en_reg = 8'hBF;
        to_poll();
        @(negedge clk);
        tmr0_flag = 1'b1;
        while (!poll_strobe) begin
            chk("R8 late flag not yet offered", int'(irq_valid), 0);
            @(negedge clk);
        end
        @(negedge clk);
        chk("R8 late flag offered next poll", int'(irq_vector), 16'h000B);
        ack_and_return();
        tmr0_flag = 1'b0;

        to_poll();
        tmr2_ovf = 1'b1;
        @(negedge clk);
        chk("R8 early flag same poll", int'(irq_valid), 1);
        chk("R8 early flag vector", int'(irq_vector), 16'h002B);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R7 no clear for tmr2", int'(clr_tmr0 | clr_tmr1), 0);
        cpu_reti = 1'b1;
        @(negedge clk);
        cpu_reti = 1'b0;
        to_poll();
        @(negedge clk);
        chk("R7 tmr2 reoffered", int'(irq_vector), 16'h002B);
        chk("R7 tmr2 reoffered valid", int'(irq_valid), 1);

        // R13: higher priority arrives while offer pending
        ext_pin_n[0] = 1'b0;
        to_poll();
        @(negedge clk);
        chk("R13 vector held", int'(irq_vector), 16'h002B);
        chk("R13 src held", int'(irq_src), 6'b100000);

        // R10: no offer while in service
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        to_poll();
        @(negedge clk);
        chk("R10 no offer before return", int'(irq_valid), 0);
        cpu_reti = 1'b1;
        @(negedge clk);
        cpu_reti = 1'b0;
        tmr2_ovf = 1'b0;
        to_poll();
        @(negedge clk);
        chk("R10 offer after return", int'(irq_vector), 16'h0003);
        ext_pin_n[0] = 1'b1;
        ack_and_return();

        // R7: serial flag is not cleared by hardware
        ser_flag = 1'b1;
        to_poll();
        @(negedge clk);
        chk("R7 serial offered", int'(irq_vector), 16'h0023);
        ack_and_return();
        to_poll();
        @(negedge clk);
        chk("R7 serial reoffered", int'(irq_valid), 1);
        ser_flag = 1'b0;
        ack_and_return();

        // R11: level mode loses a pulse that ends before the poll
        ext_edge = 2'b00;
        to_poll();
        @(negedge clk);
        ext_pin_n[1] = 1'b0;
        to_poll();
        ext_pin_n[1] = 1'b1;
        @(negedge clk);
        chk("R11 short level pulse lost", int'(irq_valid), 0);
        to_poll();
        ext_pin_n[1] = 1'b0;
        @(negedge clk);
        chk("R11 level low offered", int'(irq_vector), 16'h0013);
        ext_pin_n[1] = 1'b1;
        ack_and_return();

        // R12: edge flag survives disable and pin release, cleared by ack
        ext_edge = 2'b01;
        en_reg = 8'h80;
        to_poll();
        @(negedge clk);
        ext_pin_n[0] = 1'b0;
        to_poll();
        @(negedge clk);
        chk("R12 disabled edge not offered", int'(irq_valid), 0);
        ext_pin_n[0] = 1'b1;
        to_poll();
        @(negedge clk);
        chk("R12 still not offered", int'(irq_valid), 0);
        en_reg = 8'h81;
        to_poll();
        @(negedge clk);
        chk("R12 held edge offered", int'(irq_vector), 16'h0003);
        chk("R12 held edge valid", int'(irq_valid), 1);
        ack_and_return();
        to_poll();
        @(negedge clk);
        chk("R12 flag cleared by ack", int'(irq_valid), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule